// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer with Packed Flush Command

This block caches translations of 4 KiB pages in a small fully associative array. Each line holds an address-space identifier, the upper twenty bits of a virtual address, a twenty-bit physical frame number and three permission bits. A lookup presents an identifier and a 32-bit virtual address. Hit or miss, the frame and the permissions come back combinationally in the same cycle. An external table walker installs translations through a refill port. Lines are allocated round-robin, and a refill whose identifier and page are already cached overwrites that line in place.

Invalidation is driven by one 32-bit command word. The word selects the extent of the flush: every line, one 4 MiB section or one 16 KiB group of pages. It can also limit the flush to a single identifier. A configuration word enables a pair of saturating hit and miss counters, and a test bit in that word clears them.

Top module: `asid_tlb`

## Requirements
- R1: After reset no line is valid, both counters read zero and statistics are disabled, so every lookup misses.
- R2: A lookup with lkValid high hits in the same cycle when a valid line has the same ASID and the same lkVa[31:12]. It then returns that line's frame on lkPfn and its permissions on lkPerm (bit 2 readable, bit 1 writable, bit 0 non-secure). lkMiss is lkValid with no hit, and lkPfn and lkPerm are zero when there is no hit.
- R3: A lookup whose ASID or page differs from every valid line misses.
- R4: A refill whose ASID and rfVa[31:12] match a valid line rewrites that line. No two valid lines ever match one lookup, and the allocation pointer does not move.
- R5: Other refills fill lines round-robin from line 0 upward and wrap after the last line. The refill after ENTRIES new ones evicts the oldest line.
- R6: Flush command bits [1:0]=0 invalidates lines regardless of address. Bit 31 set limits the flush to lines whose ASID equals command bits [30:29]. Bit 31 clear flushes every ASID.
- R7: Flush mode 2 invalidates lines whose va[31:22] equals command bits [19:10].
- R8: Flush mode 3 invalidates lines whose va[31:14] equals command bits [19:2].
- R9: Flush mode 1 changes nothing.
- R10: A flush takes effect at the clock edge that samples it. A lookup in that cycle sees the lines as they were before the flush. A refill in the same cycle leaves its line valid.
- R11: Configuration bit 31 enables statistics. While it is set and bit 30 is clear, each lookup increments the hit or the miss counter. Otherwise the counters hold.
- R12: While configuration bit 30 is set, both counters are held at zero. After it clears, counting resumes from zero.
- R13: A counter at all ones stays at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkAsid | input | 2 | Lookup address-space identifier |
| lkVa | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup hit |
| lkMiss | output | 1 | Lookup miss |
| lkPfn | output | 20 | Physical frame number on hit |
| lkPerm | output | 3 | Readable, writable, non-secure on hit |
| rfValid | input | 1 | Refill request |
| rfAsid | input | 2 | Refill identifier |
| rfVa | input | 32 | Refill virtual address |
| rfPfn | input | 20 | Refill frame number |
| rfPerm | input | 3 | Refill permissions |
| flValid | input | 1 | Flush command strobe |
| flCmd | input | 32 | Packed flush command |
| cfgValid | input | 1 | Configuration write strobe |
| cfgWord | input | 32 | Configuration word |
| hitCount | output | CNT_W | Hit counter |
| missCount | output | CNT_W | Miss counter |

## Verification
The bench builds the block with four lines and 4-bit counters. At that size, round-robin wrap-around and counter saturation each take only a few operations. It sweeps every flush mode against every setting of the ASID qualifier and every ASID, each time over four lines. Those lines are placed so that section and group boundaries separate them differently. Expected lookup results and counter values come from a bench model written from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 2;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int SECT_LO = 10;  // va[31:22] within the page number
  localparam int GRP_LO  = 2;   // va[31:14] within the page number

  typedef struct packed {
    logic rd;
    logic wr;
    logic ns;
  } perm_t;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_RSVD    = 2'd1,
    FL_SECTION = 2'd2,
    FL_GROUP   = 2'd3
  } flmode_t;

  typedef struct packed {
    logic              flush;
    flmode_t           mode;
    logic              asidChk;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  tag;
    logic              refill;
  } strobe_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ASID_W-1:0] rfAsid,
  input  logic [VPN_W-1:0]  rfVpn,
  input  logic [PFN_W-1:0]  rfPfn,
  input  perm_t             rfPerm,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHitRaw,
  output logic [PFN_W-1:0]  lkPfnRaw,
  output perm_t             lkPermRaw,
  output logic              rfDup,
  output logic [IDX_W-1:0]  rfDupIdx
);
  logic [ENTRIES-1:0] validQ;
  logic [ASID_W-1:0]  asidQ [ENTRIES];
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ  [ENTRIES];
  perm_t              permQ [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] rfMatch;
  logic [ENTRIES-1:0] flHit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_line
    logic addrOk;
    always_comb begin
      unique case (strb.mode)
        FL_ALL:     addrOk = 1'b1;
        FL_SECTION: addrOk = (vpnQ[i][VPN_W-1:SECT_LO] == strb.tag[VPN_W-1:SECT_LO]);
        FL_GROUP:   addrOk = (vpnQ[i][VPN_W-1:GRP_LO] == strb.tag[VPN_W-1:GRP_LO]);
        default:    addrOk = 1'b0;
      endcase
    end
    assign flHit[i]   = validQ[i] && addrOk && (!strb.asidChk || asidQ[i] == strb.asid);
    assign lkMatch[i] = validQ[i] && asidQ[i] == lkAsid && vpnQ[i] == lkVpn;
    assign rfMatch[i] = validQ[i] && asidQ[i] == rfAsid && vpnQ[i] == rfVpn;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
      end else begin
        if (strb.flush && flHit[i]) validQ[i] <= 1'b0;
        if (strb.refill && wrIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          asidQ[i]  <= rfAsid;
          vpnQ[i]   <= rfVpn;
          pfnQ[i]   <= rfPfn;
          permQ[i]  <= rfPerm;
        end
      end
    end
  end

  always_comb begin
    lkPfnRaw  = '0;
    lkPermRaw = '0;
    rfDupIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lkPfnRaw  = lkPfnRaw | ({PFN_W{lkMatch[i]}} & pfnQ[i]);
      lkPermRaw = lkPermRaw | ({3{lkMatch[i]}} & permQ[i]);
      if (rfMatch[i]) rfDupIdx = IDX_W'(i);
    end
  end
  assign lkHitRaw = |lkMatch;
  assign rfDup    = |rfMatch;

  // R4: in-place refill keeps lookups unambiguous
  assert_unique_lookup_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));

  // R6: unqualified flush-all with no refill leaves nothing valid
  assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flush && strb.mode == FL_ALL && !strb.asidChk && !strb.refill) |=> validQ == '0);

  // R9: reserved mode with no refill leaves line state untouched
  assert_rsvd_noop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flush && strb.mode == FL_RSVD && !strb.refill) |=> $stable(validQ));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             lkHit,
  input  logic             rfValid,
  input  logic             rfDup,
  input  logic [IDX_W-1:0] rfDupIdx,
  input  logic             flValid,
  input  logic [31:0]      flCmd,
  input  logic             cfgValid,
  input  logic             cfgEnBit,
  input  logic             cfgTestBit,
  output strobe_t          strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic statsEn, statsTest;

  assign strb.flush   = flValid;
  assign strb.mode    = flmode_t'(flCmd[1:0]);
  assign strb.asidChk = flCmd[31];
  assign strb.asid    = flCmd[29 +: ASID_W];
  assign strb.tag     = flCmd[VPN_W-1:0];
  assign strb.refill  = rfValid;
  assign wrIdx        = rfDup ? rfDupIdx : rrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (rfValid && !rfDup) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statsEn   <= 1'b0;
      statsTest <= 1'b0;
    end else if (cfgValid) begin
      statsEn   <= cfgEnBit;
      statsTest <= cfgTestBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || statsTest) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (lkValid && statsEn) begin
      if (lkHit && hitCount != CNT_MAX) hitCount <= hitCount + 1'b1;
      if (!lkHit && missCount != CNT_MAX) missCount <= missCount + 1'b1;
    end
  end

  assert_rr_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rfValid && !rfDup) |=> rrPtr == (($past(rrPtr) == LAST_IDX) ? '0 : $past(rrPtr) + 1'b1));

  assert_dup_holds_ptr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rfValid && rfDup) |=> $stable(rrPtr));

  assert_stats_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!statsEn && !statsTest) |=> ($stable(hitCount) && $stable(missCount)));

  assert_test_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    statsTest |=> (hitCount == '0 && missCount == '0));

  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount == CNT_MAX && !statsTest) |=> hitCount == CNT_MAX);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [1:0]       lkAsid,
  input  logic [31:0]      lkVa,
  output logic             lkHit,
  output logic             lkMiss,
  output logic [19:0]      lkPfn,
  output logic [2:0]       lkPerm,
  input  logic             rfValid,
  input  logic [1:0]       rfAsid,
  input  logic [31:0]      rfVa,
  input  logic [19:0]      rfPfn,
  input  logic [2:0]       rfPerm,
  input  logic             flValid,
  input  logic [31:0]      flCmd,
  input  logic             cfgValid,
  input  logic [31:0]      cfgWord,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  strobe_t          strb;
  logic [IDX_W-1:0] wrIdx, rfDupIdx;
  logic             rfDup, lkHitRaw;
  logic [PFN_W-1:0] lkPfnRaw;
  perm_t            lkPermRaw;

  logic unusedOk;
  assign unusedOk = ^{lkVa[11:0], rfVa[11:0], cfgWord[29:0]};

  tlb_ctrl #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkHit(lkHitRaw),
    .rfValid(rfValid), .rfDup(rfDup), .rfDupIdx(rfDupIdx),
    .flValid(flValid), .flCmd(flCmd),
    .cfgValid(cfgValid), .cfgEnBit(cfgWord[31]), .cfgTestBit(cfgWord[30]),
    .strb(strb), .wrIdx(wrIdx),
    .hitCount(hitCount), .missCount(missCount)
  );

  tlb_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .wrIdx(wrIdx),
    .rfAsid(rfAsid), .rfVpn(rfVa[31:12]), .rfPfn(rfPfn), .rfPerm(perm_t'(rfPerm)),
    .lkAsid(lkAsid), .lkVpn(lkVa[31:12]),
    .lkHitRaw(lkHitRaw), .lkPfnRaw(lkPfnRaw), .lkPermRaw(lkPermRaw),
    .rfDup(rfDup), .rfDupIdx(rfDupIdx)
  );

  assign lkHit  = lkValid && lkHitRaw;
  assign lkMiss = lkValid && !lkHitRaw;
  assign lkPfn  = lkHit ? lkPfnRaw : '0;
  assign lkPerm = lkHit ? lkPermRaw : '0;

  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit + lkMiss) == {1'b0, lkValid});
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 0, rstN = 0;
  logic lkValid = 0, rfValid = 0, flValid = 0, cfgValid = 0;
  logic [1:0] lkAsid = 0, rfAsid = 0;
  logic [31:0] lkVa = 0, rfVa = 0, flCmd = 0, cfgWord = 0;
  logic [19:0] rfPfn = 0, lkPfn;
  logic [2:0] rfPerm = 0, lkPerm;
  logic lkHit, lkMiss;
  logic [CW-1:0] hitCount, missCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.ENTRIES(NE), .CNT_W(CW)) u_asid_tlb (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAsid(lkAsid), .lkVa(lkVa),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPfn(lkPfn), .lkPerm(lkPerm),
    .rfValid(rfValid), .rfAsid(rfAsid), .rfVa(rfVa), .rfPfn(rfPfn), .rfPerm(rfPerm),
    .flValid(flValid), .flCmd(flCmd), .cfgValid(cfgValid), .cfgWord(cfgWord),
    .hitCount(hitCount), .missCount(missCount));

  int checks = 0, errors = 0;
  bit done = 0;

  // requirement model
  bit          mv [NE];
  logic [1:0]  ma [NE];
  logic [19:0] mvpn [NE];
  logic [19:0] mpfn [NE];
  logic [2:0]  mperm [NE];
  int          mptr = 0;
  bit          mEn = 0, mTest = 0;
  logic [CW-1:0] mHit = 0, mMiss = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit flMatch(input int i, input logic [31:0] fc);
    logic [31:0] va;
    bit addrOk;
    va = {mvpn[i], 12'h000};
    case (fc[1:0])
      2'd0: addrOk = 1;
      2'd2: addrOk = (va[31:22] == fc[19:10]);
      2'd3: addrOk = (va[31:14] == fc[19:2]);
      default: addrOk = 0;
    endcase
    return mv[i] && addrOk && (!fc[31] || ma[i] == fc[30:29]);
  endfunction

  task automatic step(input bit dl, input logic [1:0] la, input logic [31:0] lva,
                      input bit df, input logic [31:0] fc,
                      input bit dr, input logic [1:0] ra, input logic [31:0] rva,
                      input logic [19:0] rp, input logic [2:0] rperm,
                      input bit dc, input logic [31:0] cw, input string tag);
    bit eh;
    logic [19:0] ep;
    logic [2:0] eperm;
    int dup;
    bit flv [NE];
    @(negedge clk);
    lkValid = dl; lkAsid = la; lkVa = lva;
    flValid = df; flCmd = fc;
    rfValid = dr; rfAsid = ra; rfVa = rva; rfPfn = rp; rfPerm = rperm;
    cfgValid = dc; cfgWord = cw;
    #1;
    if (dl) begin
      eh = 0; ep = 0; eperm = 0;
      for (int i = 0; i < NE; i++)
        if (mv[i] && ma[i] == la && mvpn[i] == lva[31:12]) begin
          eh = 1; ep = mpfn[i]; eperm = mperm[i];
        end
      chk(lkHit == eh, tag, "hit", 32'(lkHit), 32'(eh));
      chk(lkMiss == !eh, tag, "miss", 32'(lkMiss), 32'(!eh));
      chk(lkPfn == ep, tag, "pfn", 32'(lkPfn), 32'(ep));
      chk(lkPerm == eperm, tag, "perm", 32'(lkPerm), 32'(eperm));
    end
    @(posedge clk);
    if (mTest) begin mHit = 0; mMiss = 0; end
    else if (dl && mEn) begin
      if (eh && mHit != CMAX) mHit++;
      if (!eh && mMiss != CMAX) mMiss++;
    end
    dup = -1;
    for (int i = 0; i < NE; i++)
      if (mv[i] && ma[i] == ra && mvpn[i] == rva[31:12]) dup = i;
    for (int i = 0; i < NE; i++) flv[i] = df && flMatch(i, fc);
    for (int i = 0; i < NE; i++) if (flv[i]) mv[i] = 0;
    if (dr) begin
      if (dup < 0) begin dup = mptr; mptr = (mptr + 1) % NE; end
      mv[dup] = 1; ma[dup] = ra; mvpn[dup] = rva[31:12]; mpfn[dup] = rp; mperm[dup] = rperm;
    end
    if (dc) begin mEn = cw[31]; mTest = cw[30]; end
  endtask

  task automatic lookup(input logic [1:0] a, input logic [31:0] va, input string tag);
    step(1, a, va, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic refill(input logic [1:0] a, input logic [31:0] va,
                        input logic [19:0] p, input logic [2:0] pm, input string tag);
    step(0, 0, 0, 0, 0, 1, a, va, p, pm, 0, 0, tag);
  endtask
  task automatic flush(input logic [31:0] fc, input string tag);
    step(0, 0, 0, 1, fc, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic config_(input logic [31:0] cw, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, cw, tag);
  endtask
  task automatic counts(input string tag);
    #2;
    chk(hitCount == mHit, tag, "hitCount", 32'(hitCount), 32'(mHit));
    chk(missCount == mMiss, tag, "missCount", 32'(missCount), 32'(mMiss));
  endtask

  localparam logic [31:0] VA0 = 32'h1234_5000, VA1 = 32'h1234_6000,
                          VA2 = 32'h1235_0000, VA3 = 32'h5678_9000;

  function automatic logic [31:0] pickVa(input int i);
    case (i) 0: return VA0; 1: return VA1; 2: return VA2; default: return VA3; endcase
  endfunction

  initial begin
    for (int i = 0; i < NE; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state
    counts("R1");
    lookup(0, VA0, "R1");
    lookup(3, 32'h0, "R1");
    counts("R1");

    // R11: disabled statistics do not count
    refill(1, VA1, 20'hABCDE, 3'b101, "R2");
    lookup(1, VA1, "R2");
    lookup(1, VA1 ^ 32'h0000_0FFF, "R2");
    lookup(0, VA1, "R3");
    lookup(1, VA1 + 32'h1000, "R3");
    counts("R11");

    // R4: in-place refill
    refill(1, VA1, 20'h11111, 3'b010, "R4");
    lookup(1, VA1, "R4");
    // R5: round robin wrap evicts oldest
    flush(32'h0, "R6");
    for (int i = 0; i < NE + 1; i++)
      refill(2'(i), 32'h0040_0000 * i, 20'h00100 + 20'(i), 3'(i), "R5");
    for (int i = 0; i < NE + 1; i++) lookup(2'(i), 32'h0040_0000 * i, "R5");

    // R6 R7 R8 R9: sweep flush modes x qualifier x ASID over four lines
    for (int md = 0; md < 4; md++)
      for (int qe = 0; qe < 2; qe++)
        for (int fa = 0; fa < 4; fa++) begin
          logic [31:0] fc;
          flush(32'h0, "R6");
          for (int i = 0; i < NE; i++)
            refill(2'(i), pickVa(i), 20'h0A000 + 20'(i * 7 + md), 3'(i + fa), "R2");
          case (md)
            0: fc = 32'h0;
            1: fc = ((VA0 & 32'hFFFF_C000) >> 12) | 32'd1;
            2: fc = ((VA0 & 32'hFFC0_0000) >> 12) | 32'd2;
            default: fc = ((VA0 & 32'hFFFF_C000) >> 12) | 32'd3;
          endcase
          fc = fc | (32'(qe) << 31) | (32'(fa) << 29);
          flush(fc, md == 0 ? "R6" : md == 1 ? "R9" : md == 2 ? "R7" : "R8");
          for (int i = 0; i < NE; i++)
            lookup(2'(i), pickVa(i), md == 0 ? "R6" : md == 1 ? "R9" : md == 2 ? "R7" : "R8");
        end

    // R10: same-cycle lookup sees pre-flush; same-cycle refill survives
    flush(32'h0, "R10");
    refill(0, VA0, 20'h22222, 3'b111, "R10");
    step(1, 0, VA0, 1, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R10");
    lookup(0, VA0, "R10");
    step(0, 0, 0, 1, 32'h0, 1, 3, VA3, 20'h33333, 3'b001, 0, 0, "R10");
    lookup(3, VA3, "R10");

    // R11 R13: enabled counting and saturation
    config_(32'h8000_0000, "R11");
    lookup(3, VA3, "R11");
    lookup(2, VA2, "R11");
    counts("R11");
    for (int k = 0; k < 20; k++) lookup(1, 32'h7000_0000, "R13");
    counts("R13");
    for (int k = 0; k < 20; k++) lookup(3, VA3, "R13");
    counts("R13");
    // R12: test pulse clears and holds, then counting restarts
    config_(32'hC000_0000, "R12");
    lookup(3, VA3, "R12");
    lookup(0, VA0, "R12");
    counts("R12");
    config_(32'h8000_0000, "R12");
    lookup(3, VA3, "R12");
    counts("R12");
    config_(32'h0, "R11");
    lookup(3, VA3, "R11");
    counts("R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule